// File: doc/BRIEF.md
# Inband Grant Header Inserter

This block sits on the egress side of a 16-port packet switch. It fills three header bytes of every outgoing packet. Two of them, called H1 and H2 here, carry the output-queue grant vector for one priority. The third, H0, is the qualifier byte, and on idle packets it also carries the number of the priority being reported. A neighbouring device that receives these packets can rebuild the full grant state of every queue for every priority from a short run of consecutive packets.

The reported priority moves on by one with each packet, whether idle or data. It counts from 0 up to the highest enabled priority and then returns to 0. A three-threshold mode shortens the cycle to priorities 0, 1 and 2. When flow control is off, H1 and H2 carry zeros. H0 still reports the rotating priority on idle packets. The grant vector is sampled when the packet starts and held for the whole header. Any change to the configuration sends the rotation back to priority 0.

Top module: `grant_hdr_inserter`

## Requirements
- R1: When `fc_en` is 0 at a packet start, `hdr_h1` and `hdr_h2` are 0 for that packet.
- R2: When `fc_en` is 1, `hdr_h1` bit n is the grant of queue n and `hdr_h2` bit n is the grant of queue 8+n, taken from the reported priority p. The priority-p vector sits at bits [16p+15:16p] of `grant_all`.
- R3: The first packet after reset reports priority 0. Each later packet reports the next priority.
- R4: After reporting the top priority, the next packet reports 0. The top is `prio_top`, where `prio_top` = 1 gives a 2-packet cycle and 3 gives a 4-packet cycle.
- R5: When `three_thr` is 1 and `prio_top` is above 2, the top is 2, so the cycle is 0,1,2.
- R6: On an idle packet (`pkt_idle`=1), `hdr_h0` has bit 7 = 1, bits [1:0] = the reported priority and the other bits 0. On a data packet, `hdr_h0` is 0.
- R7: Data packets carry the grant vector in `hdr_h1`/`hdr_h2` exactly as idle packets do, and they also advance the rotation.
- R8: A change of `fc_en`, `three_thr` or `prio_top` resets the rotation. A packet starting in the same cycle as the change reports priority 0, and the next packet reports 1.
- R9: The header bytes update one clock after `pkt_start` and hold until the next `pkt_start`. Changes to `grant_all` between starts have no effect on them.
- R10: After reset, all header bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 1 | Flow control enable: grants go into H1/H2 |
| three_thr | input | 1 | Three-threshold mode: limits rotation to priorities 0..2 |
| prio_top | input | 2 | Highest enabled priority |
| pkt_start | input | 1 | One-cycle strobe at the start of each packet |
| pkt_idle | input | 1 | Qualifies `pkt_start`: 1 for idle, 0 for data |
| grant_all | input | 64 | Grant vectors, 16 bits per priority |
| hdr_h0 | output | 8 | Qualifier byte |
| hdr_h1 | output | 8 | Grants for queues 0..7 |
| hdr_h2 | output | 8 | Grants for queues 8..15 |

## Verification
A configuration change and a packet start can land in the same clock, and the rotation reset then has to win over the advance. The bench drives a new `prio_top` or `three_thr` in the very cycle it raises `pkt_start`. It expects that packet to report priority 0 in H0 and to carry the priority-0 grants in H1/H2, and it expects the following packet to report priority 1. It also checks the plain wrap under each cycle length and the zeroed grant bytes with flow control off.

// File: rtl/gh_pkg.sv
package gh_pkg;
  // Priority that three-threshold mode stops at
  localparam int unsigned GH_THREE_TOP = 2;
  // H0 bit flagging an idle packet
  localparam int unsigned GH_IDLE_BIT  = 7;

  function automatic logic [7:0] gh_make_h0(input logic idle, input logic [6:0] prio);
    logic [7:0] b;
    b = 8'h00;
    if (idle) begin
      b[GH_IDLE_BIT] = 1'b1;
      b[6:0] = prio;
    end
    return b;
  endfunction
endpackage

// File: rtl/gh_prio_seq.sv
module gh_prio_seq #(
  parameter int unsigned NUM_PRIO = 4,
  localparam int unsigned PRIO_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_start,
  input  logic              fc_en,
  input  logic              three_thr,
  input  logic [PRIO_W-1:0] prio_top,
  output logic [PRIO_W-1:0] cur_prio
);
  import gh_pkg::*;

  localparam int unsigned CFG_W = PRIO_W + 2;

  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              cfg_chg;
  logic [PRIO_W-1:0] top_eff;
  logic [PRIO_W-1:0] cnt_q;

  assign cfg_now = {fc_en, three_thr, prio_top};
  assign cfg_chg = (cfg_now != cfg_q);

  always_comb begin
    top_eff = prio_top;
    if (three_thr && (prio_top > PRIO_W'(GH_THREE_TOP)))
      top_eff = PRIO_W'(GH_THREE_TOP);
  end

  // A configuration change forces the reported priority to 0 at once
  assign cur_prio = cfg_chg ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cfg_q <= cfg_now;
    end else begin
      cfg_q <= cfg_now;
      if (pkt_start)
        cnt_q <= (cur_prio == top_eff) ? '0 : cur_prio + 1'b1;
      else if (cfg_chg)
        cnt_q <= '0;
    end
  end

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && !cfg_chg && cnt_q == top_eff) |=> (cnt_q == '0));

  assert_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chg) |-> (cnt_q <= top_eff));

  assert_cfg_reset_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_chg && !pkt_start) |=> (cnt_q == '0));
endmodule

// File: rtl/gh_grant_sel.sv
module gh_grant_sel #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned NUM_PRIO  = 4,
  localparam int unsigned PRIO_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic [NUM_PRIO*NUM_PORTS-1:0] grant_all,
  input  logic [PRIO_W-1:0]             sel,
  output logic [NUM_PORTS-1:0]          vec
);
  logic [NUM_PORTS-1:0] lane [NUM_PRIO];

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_lane
    assign lane[p] = grant_all[p*NUM_PORTS +: NUM_PORTS];
  end

  always_comb begin
    vec = '0;
    for (int p = 0; p < NUM_PRIO; p++)
      if (sel == PRIO_W'(p)) vec = lane[p];
  end
endmodule

// File: rtl/grant_hdr_inserter.sv
module grant_hdr_inserter #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned NUM_PRIO  = 4,
  localparam int unsigned PRIO_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1,
  localparam int unsigned HALF   = NUM_PORTS / 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fc_en,
  input  logic                          three_thr,
  input  logic [PRIO_W-1:0]             prio_top,
  input  logic                          pkt_start,
  input  logic                          pkt_idle,
  input  logic [NUM_PRIO*NUM_PORTS-1:0] grant_all,
  output logic [7:0]                    hdr_h0,
  output logic [HALF-1:0]               hdr_h1,
  output logic [NUM_PORTS-HALF-1:0]     hdr_h2
);
  import gh_pkg::*;

  logic [PRIO_W-1:0]    cur_prio;
  logic [NUM_PORTS-1:0] sel_vec;

  gh_prio_seq #(.NUM_PRIO(NUM_PRIO)) i_seq (
    .clk(clk), .rst(rst), .pkt_start(pkt_start),
    .fc_en(fc_en), .three_thr(three_thr), .prio_top(prio_top),
    .cur_prio(cur_prio)
  );

  gh_grant_sel #(.NUM_PORTS(NUM_PORTS), .NUM_PRIO(NUM_PRIO)) i_sel (
    .grant_all(grant_all), .sel(cur_prio), .vec(sel_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_h0 <= '0;
      hdr_h1 <= '0;
      hdr_h2 <= '0;
    end else if (pkt_start) begin
      hdr_h0 <= gh_make_h0(pkt_idle, 7'(cur_prio));
      hdr_h1 <= fc_en ? sel_vec[HALF-1:0] : '0;
      hdr_h2 <= fc_en ? sel_vec[NUM_PORTS-1:HALF] : '0;
    end
  end

  assert_fc_off_R1: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && !fc_en) |=> (hdr_h1 == '0 && hdr_h2 == '0));

  assert_data_h0_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && !pkt_idle) |=> (hdr_h0 == 8'h00));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!pkt_start) |=> ($stable(hdr_h0) && $stable(hdr_h1) && $stable(hdr_h2)));
endmodule

// File: tb/test_grant_hdr_inserter.sv
module test_grant_hdr_inserter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        fc_en, three_thr, pkt_start, pkt_idle;
  logic [1:0]  prio_top;
  logic [63:0] grant_all;
  logic [7:0]  hdr_h0, hdr_h1, hdr_h2;

  int checks = 0;
  int errors = 0;

  logic [15:0] gv [4];
  int          cnt_m;
  logic [3:0]  cfg_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  grant_hdr_inserter i_grant_hdr_inserter (
    .clk(clk), .rst(rst), .fc_en(fc_en), .three_thr(three_thr),
    .prio_top(prio_top), .pkt_start(pkt_start), .pkt_idle(pkt_idle),
    .grant_all(grant_all), .hdr_h0(hdr_h0), .hdr_h1(hdr_h1), .hdr_h2(hdr_h2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int top_m(input logic thr, input logic [1:0] t);
    return (thr && t > 2) ? 2 : int'(t);
  endfunction

  // Send one packet, optionally with a new configuration in the same cycle
  task automatic pkt(input logic idle, input logic f, input logic thr,
                     input logic [1:0] t, input string req);
    int p;
    logic [7:0] e0, e1, e2;
    @(negedge clk);
    fc_en = f; three_thr = thr; prio_top = t;
    pkt_start = 1'b1; pkt_idle = idle;
    if ({f, thr, t} != cfg_prev) begin
      p = 0;
      cfg_prev = {f, thr, t};
    end else p = cnt_m;
    cnt_m = (p == top_m(thr, t)) ? 0 : p + 1;
    e0 = idle ? (8'h80 | 8'(p)) : 8'h00;
    e1 = f ? gv[p][7:0] : 8'h00;
    e2 = f ? gv[p][15:8] : 8'h00;
    @(negedge clk);
    pkt_start = 1'b0;
    chk(hdr_h0 == e0, {req, " h0"}, hdr_h0, e0);
    chk(hdr_h1 == e1, {req, " h1"}, hdr_h1, e1);
    chk(hdr_h2 == e2, {req, " h2"}, hdr_h2, e2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pkt_start = 1'b0; pkt_idle = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cnt_m = 0;
    cfg_prev = {fc_en, three_thr, prio_top};
  endtask

  // R10: reset state
  task automatic t_reset();
    do_reset();
    chk(hdr_h0 == 0 && hdr_h1 == 0 && hdr_h2 == 0, "R10 reset", {hdr_h0, hdr_h1, hdr_h2}, 0);
  endtask

  // R3 R4 R2: four-priority rotation on idle packets
  task automatic t_four();
    for (int i = 0; i < 9; i++) pkt(1'b1, 1'b1, 1'b0, 2'd3, "R3/R4 four-cycle R2");
  endtask

  // R4: two-priority cycle, mixed with data packets (R7)
  task automatic t_two();
    for (int i = 0; i < 5; i++) pkt(i[0], 1'b1, 1'b0, 2'd1, "R4 two-cycle R7");
  endtask

  // R5: three-threshold mode
  task automatic t_three();
    for (int i = 0; i < 7; i++) pkt(1'b1, 1'b1, 1'b1, 2'd3, "R5 three-thr");
  endtask

  // R6 R7: data packets carry grants, no priority
  task automatic t_data();
    for (int i = 0; i < 4; i++) pkt(1'b0, 1'b1, 1'b0, 2'd3, "R6/R7 data");
  endtask

  // R1: flow control off
  task automatic t_fc_off();
    for (int i = 0; i < 4; i++) pkt(i[0], 1'b0, 1'b0, 2'd3, "R1 fc off");
  endtask

  // R8: configuration change in same cycle as packet start, then alone
  task automatic t_cfg_same_cycle();
    pkt(1'b1, 1'b1, 1'b0, 2'd3, "R8 setup");
    pkt(1'b1, 1'b1, 1'b0, 2'd3, "R8 setup");
    pkt(1'b1, 1'b1, 1'b0, 2'd2, "R8 same-cycle change");
    pkt(1'b1, 1'b1, 1'b0, 2'd2, "R8 after change");
    pkt(1'b1, 1'b1, 1'b0, 2'd2, "R8 after change");
    @(negedge clk); three_thr = 1'b1; prio_top = 2'd1;
    @(negedge clk);
    cnt_m = 0; cfg_prev = {fc_en, three_thr, prio_top};
    pkt(1'b1, 1'b1, 1'b1, 2'd1, "R8 idle-cycle change");
    pkt(1'b1, 1'b1, 1'b1, 2'd1, "R8 idle-cycle change");
  endtask

  // R9: header bytes hold while grants change between starts
  task automatic t_hold();
    logic [7:0] h0s, h1s, h2s;
    pkt(1'b1, 1'b1, 1'b0, 2'd3, "R9 setup");
    h0s = hdr_h0; h1s = hdr_h1; h2s = hdr_h2;
    grant_all = ~grant_all;
    repeat (3) @(negedge clk);
    chk(hdr_h0 == h0s && hdr_h1 == h1s && hdr_h2 == h2s, "R9 hold",
        {hdr_h0, hdr_h1, hdr_h2}, {h0s, h1s, h2s});
    grant_all = ~grant_all;
  endtask

  initial begin
    gv[0] = 16'h12F0; gv[1] = 16'h3C81; gv[2] = 16'hA55A; gv[3] = 16'h0FE7;
    grant_all = {gv[3], gv[2], gv[1], gv[0]};
    fc_en = 1'b1; three_thr = 1'b0; prio_top = 2'd3;
    rst = 1'b1; pkt_start = 1'b0; pkt_idle = 1'b0;
    t_reset();
    t_four();
    t_two();
    t_three();
    t_data();
    t_fc_off();
    t_cfg_same_cycle();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule